// File: doc/BRIEF.md
# Multiprocessor Shared Address Decoder

This block sits on the address path of a bus shared by a cluster of processors and external memory. It turns each presented 32-bit word address into a target select. The lowest part of the map belongs to the processor that owns the bus, and covers its I/O registers plus two internal memory views: a normal-word view and a short-word view. Above that, a multiprocessor region is divided into windows by a 3-bit processor ID field. Each ID in use selects one processor's internal memory. The all-ones ID is a broadcast window, and a write to it selects every processor in the same cycle. Everything from `0x0040_0000` upward is external memory. It is split into four banks whose common size comes from a programmable size field, and a nonbanked area follows the banks.

The outputs are a one-hot processor select vector, a one-hot bank select vector, a region code and an error flag. The decode itself is combinational. A parameter places one register stage in front of the outputs, so that their timing can be closed on a wide bus.

Top module: `mp_addr_decoder`

## Requirements
- R1: When `req_valid_i` is low, the next outputs are all zero: no processor select, no bank select, region code 0 and error 0.
- R2: A valid address below `0x0040_0000` whose ID field `addr[21:19]` is 000 decodes as local space with no selects. The region code is 1 (I/O registers) when `addr[18:17]` is 00, 2 (normal-word memory) when it is 01, and 3 (short-word memory) when `addr[18]` is 1.
- R3: A valid address below `0x0040_0000` with ID 1 to NUM_PROC sets only `proc_sel_o[ID-1]`, gives region code 4 and no error, for reads and writes alike.
- R4: A valid write with ID 111 below `0x0040_0000` sets every bit of `proc_sel_o`, gives region code 5 and no error.
- R5: A valid read with ID 111 below `0x0040_0000` sets no select, gives region code 5 and raises `err_o`.
- R6: For a valid address at or above `0x0040_0000`, let k = (addr - `0x0040_0000`) >> (13 + `bank_size_i`). If k < 4, only `bank_sel_o[k]` is set, the region code is 6, and no processor is selected.
- R7: For a valid external address with k ≥ 4, no bank and no processor is selected, and the region code is 7.
- R8: Bank boundaries follow `bank_size_i` over its full range 0 to 15. Changing the field alone moves a fixed address between banks and the nonbanked area.
- R9: With REG_OUT = 1, the outputs show the decode of the inputs sampled at the previous rising clock edge and hold until the next edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| req_valid_i | input | 1 | An address is presented this cycle |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 32 | Word address on the shared bus |
| bank_size_i | input | 4 | Bank size field; each bank spans 2^(13+value) words |
| proc_sel_o | output | 6 | One-hot processor select, all ones for a broadcast write |
| bank_sel_o | output | 4 | One-hot external bank select |
| region_o | output | 3 | Region code: 0 none, 1 I/O, 2 normal, 3 short, 4 processor, 5 broadcast, 6 bank, 7 nonbanked |
| err_o | output | 1 | Broadcast read or unmapped processor ID |

## Verification
The corners that are hardest to reach are the bank edges. They sit at addresses that depend on `bank_size_i`, so a fixed address list would only test one layout. The stimulus applies the last and first word on each side of the bank-3 to nonbanked edge at the smallest, a middle and the largest size. It also moves one fixed address between areas by changing the size field alone. The broadcast window is driven with both a write and a read at the same address, so that the all-ones select and the error path are each seen against the same decode.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

    typedef enum logic [2:0] {
        RGN_NONE    = 3'd0,
        RGN_IOREG   = 3'd1,
        RGN_NORMAL  = 3'd2,
        RGN_SHORT   = 3'd3,
        RGN_PROC    = 3'd4,
        RGN_BCAST   = 3'd5,
        RGN_BANK    = 3'd6,
        RGN_NONBANK = 3'd7
    } region_e;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned ID_W    = 3;
    localparam int unsigned ID_LSB  = 19;
    localparam int unsigned SUB_LSB = 17;

endpackage

// File: rtl/mpd_mp_decode.sv
module mpd_mp_decode
    import mpd_pkg::*;
#(
    parameter int unsigned NUM_PROC = 6
) (
    input  logic                 hit_i,
    input  logic                 write_i,
    input  logic [ID_W-1:0]      id_i,
    input  logic [1:0]           sub_i,
    output logic [NUM_PROC-1:0]  proc_sel_o,
    output region_e              region_o,
    output logic                 err_o
);

    localparam logic [ID_W-1:0] ID_LOCAL = '0;
    localparam logic [ID_W-1:0] ID_BCAST = '1;

    logic [NUM_PROC-1:0] id_match;
    logic                id_mapped;

    for (genvar g = 0; g < NUM_PROC; g++) begin : g_id
        assign id_match[g] = (id_i == ID_W'(g + 1));
    end

    assign id_mapped = |id_match;

    always_comb begin
        proc_sel_o = '0;
        region_o   = RGN_NONE;
        err_o      = 1'b0;
        if (hit_i) begin
            if (id_i == ID_LOCAL) begin
                if (sub_i[1])
                    region_o = RGN_SHORT;
                else if (sub_i[0])
                    region_o = RGN_NORMAL;
                else
                    region_o = RGN_IOREG;
            end else if (id_i == ID_BCAST) begin
                region_o = RGN_BCAST;
                if (write_i)
                    proc_sel_o = '1;
                else
                    err_o = 1'b1;
            end else if (id_mapped) begin
                region_o   = RGN_PROC;
                proc_sel_o = id_match;
            end else begin
                err_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mpd_bank_decode.sv
module mpd_bank_decode
    import mpd_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 4,
    parameter int unsigned SIZE_W     = 4,
    parameter int unsigned BASE_SHIFT = 13,
    parameter logic [ADDR_W-1:0] EXT_BASE = 32'h0040_0000
) (
    input  logic                  hit_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [SIZE_W-1:0]     size_i,
    output logic [NUM_BANKS-1:0]  bank_sel_o,
    output region_e               region_o
);

    localparam int unsigned SH_W = $clog2(BASE_SHIFT + (1 << SIZE_W));

    logic [ADDR_W-1:0]    offset;
    logic [SH_W-1:0]      shamt;
    logic [ADDR_W-1:0]    bank_idx;
    logic [NUM_BANKS-1:0] bank_hit;
    logic                 past_banks;

    assign offset     = addr_i - EXT_BASE;
    assign shamt      = SH_W'(BASE_SHIFT) + SH_W'(size_i);
    assign bank_idx   = offset >> shamt;
    assign past_banks = (bank_idx >= ADDR_W'(NUM_BANKS));

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign bank_hit[g] = (bank_idx == ADDR_W'(g));
    end

    always_comb begin
        bank_sel_o = '0;
        region_o   = RGN_NONE;
        if (hit_i) begin
            if (past_banks) begin
                region_o = RGN_NONBANK;
            end else begin
                region_o   = RGN_BANK;
                bank_sel_o = bank_hit;
            end
        end
    end

endmodule

// File: rtl/mpd_out_stage.sv
module mpd_out_stage
    import mpd_pkg::*;
#(
    parameter int unsigned NUM_PROC  = 6,
    parameter int unsigned NUM_BANKS = 4,
    parameter bit          REG_OUT   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PROC-1:0]   proc_sel_i,
    input  logic [NUM_BANKS-1:0]  bank_sel_i,
    input  region_e               region_i,
    input  logic                  err_i,
    output logic [NUM_PROC-1:0]   proc_sel_o,
    output logic [NUM_BANKS-1:0]  bank_sel_o,
    output region_e               region_o,
    output logic                  err_o
);

    typedef struct packed {
        logic [NUM_PROC-1:0]  proc_sel;
        logic [NUM_BANKS-1:0] bank_sel;
        region_e              region;
        logic                 err;
    } dec_out_t;

    localparam dec_out_t OUT_IDLE = '{proc_sel: '0, bank_sel: '0, region: RGN_NONE, err: 1'b0};

    dec_out_t out_d;
    dec_out_t out_q;

    always_comb begin
        out_d          = OUT_IDLE;
        out_d.proc_sel = proc_sel_i;
        out_d.bank_sel = bank_sel_i;
        out_d.region   = region_i;
        out_d.err      = err_i;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                out_q <= OUT_IDLE;
            else
                out_q <= out_d;
        end
    end else begin : g_pass
        assign out_q = out_d;
    end

    assign proc_sel_o = out_q.proc_sel;
    assign bank_sel_o = out_q.bank_sel;
    assign region_o   = out_q.region;
    assign err_o      = out_q.err;

endmodule

// File: rtl/mp_addr_decoder.sv
module mp_addr_decoder
    import mpd_pkg::*;
#(
    parameter int unsigned NUM_PROC   = 6,
    parameter int unsigned NUM_BANKS  = 4,
    parameter int unsigned SIZE_W     = 4,
    parameter int unsigned BASE_SHIFT = 13,
    parameter bit          REG_OUT    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [31:0]          req_addr_i,
    input  logic [SIZE_W-1:0]    bank_size_i,
    output logic [NUM_PROC-1:0]  proc_sel_o,
    output logic [NUM_BANKS-1:0] bank_sel_o,
    output logic [2:0]           region_o,
    output logic                 err_o
);

    localparam logic [ADDR_W-1:0] EXT_BASE = 32'h0040_0000;

    logic                 ext_hit;
    logic                 mp_hit;
    logic [NUM_PROC-1:0]  mp_proc_sel;
    region_e              mp_region;
    logic                 mp_err;
    logic [NUM_BANKS-1:0] ext_bank_sel;
    region_e              ext_region;
    region_e              comb_region;
    region_e              out_region;

    assign ext_hit = req_valid_i && (req_addr_i >= EXT_BASE);
    assign mp_hit  = req_valid_i && (req_addr_i <  EXT_BASE);

    mpd_mp_decode #(
        .NUM_PROC (NUM_PROC)
    ) u_mp (
        .hit_i      (mp_hit),
        .write_i    (req_write_i),
        .id_i       (req_addr_i[ID_LSB +: ID_W]),
        .sub_i      (req_addr_i[SUB_LSB +: 2]),
        .proc_sel_o (mp_proc_sel),
        .region_o   (mp_region),
        .err_o      (mp_err)
    );

    mpd_bank_decode #(
        .NUM_BANKS  (NUM_BANKS),
        .SIZE_W     (SIZE_W),
        .BASE_SHIFT (BASE_SHIFT),
        .EXT_BASE   (EXT_BASE)
    ) u_bank (
        .hit_i      (ext_hit),
        .addr_i     (req_addr_i),
        .size_i     (bank_size_i),
        .bank_sel_o (ext_bank_sel),
        .region_o   (ext_region)
    );

    assign comb_region = ext_hit ? ext_region : mp_region;

    mpd_out_stage #(
        .NUM_PROC  (NUM_PROC),
        .NUM_BANKS (NUM_BANKS),
        .REG_OUT   (REG_OUT)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_sel_i (mp_proc_sel),
        .bank_sel_i (ext_bank_sel),
        .region_i   (comb_region),
        .err_i      (mp_err),
        .proc_sel_o (proc_sel_o),
        .bank_sel_o (bank_sel_o),
        .region_o   (out_region),
        .err_o      (err_o)
    );

    assign region_o = out_region;

    // R3: outside the broadcast region at most one processor is selected
    a_r3_proc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o != 3'd5) |-> $onehot0(proc_sel_o));

    // R6: banks are selected one at a time
    a_r6_bank_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel_o));

    // R6: a bank select never coexists with a processor select
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_sel_o) |-> (proc_sel_o == '0 && region_o == 3'd6));

    // R5: an error never comes with a select
    a_r5_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (proc_sel_o == '0 && bank_sel_o == '0));

    // R7: the nonbanked area selects nothing
    a_r7_nonbank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o == 3'd7) |-> (bank_sel_o == '0 && proc_sel_o == '0 && !err_o));

    if (REG_OUT) begin : g_chk_reg
        // R1: an idle request gives idle outputs one cycle later
        a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid_i |=> (region_o == 3'd0 && proc_sel_o == '0 && bank_sel_o == '0 && !err_o));
    end

endmodule

// File: tb/mp_addr_decoder_bench.sv
module mp_addr_decoder_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [3:0]  bank_size_i = '0;
    logic [5:0]  proc_sel_o;
    logic [3:0]  bank_sel_o;
    logic [2:0]  region_o;
    logic        err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mp_addr_decoder u_mp_addr_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .bank_size_i (bank_size_i),
        .proc_sel_o  (proc_sel_o),
        .bank_sel_o  (bank_sel_o),
        .region_o    (region_o),
        .err_o       (err_o)
    );

    task automatic check_out(input string tag, input logic [5:0] e_proc,
                             input logic [3:0] e_bank, input logic [2:0] e_rgn,
                             input logic e_err);
        n_checks++;
        if (proc_sel_o !== e_proc || bank_sel_o !== e_bank ||
            region_o !== e_rgn || err_o !== e_err) begin
            n_fails++;
            $display("FAIL %s: got proc=%h bank=%h rgn=%0d err=%b, expected proc=%h bank=%h rgn=%0d err=%b",
                     tag, proc_sel_o, bank_sel_o, region_o, err_o, e_proc, e_bank, e_rgn, e_err);
        end
    endtask

    // drive at a falling edge, check at the next falling edge (one register)
    task automatic apply(input logic v, input logic w, input logic [31:0] a,
                         input logic [3:0] sz);
        @(negedge clk);
        req_valid_i = v;
        req_write_i = w;
        req_addr_i  = a;
        bank_size_i = sz;
        @(negedge clk);
    endtask

    task automatic t_reset;
        #1;
        check_out("R9 reset", 6'h00, 4'h0, 3'd0, 1'b0);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_addr_i  = 32'h0040_0000;
        @(negedge clk);
        check_out("R9 reset held", 6'h00, 4'h0, 3'd0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle;
        apply(1'b0, 1'b1, 32'h0040_0000, 4'd0);
        check_out("R1 idle ext", 6'h00, 4'h0, 3'd0, 1'b0);
        apply(1'b0, 1'b1, 32'h0038_0000, 4'd0);
        check_out("R1 idle bcast", 6'h00, 4'h0, 3'd0, 1'b0);
    endtask

    task automatic t_local;
        apply(1'b1, 1'b0, 32'h0000_1234, 4'd0);
        check_out("R2 ioreg", 6'h00, 4'h0, 3'd1, 1'b0);
        apply(1'b1, 1'b1, 32'h0002_0010, 4'd0);
        check_out("R2 normal", 6'h00, 4'h0, 3'd2, 1'b0);
        apply(1'b1, 1'b0, 32'h0004_0000, 4'd0);
        check_out("R2 short low", 6'h00, 4'h0, 3'd3, 1'b0);
        apply(1'b1, 1'b0, 32'h0007_FFFF, 4'd0);
        check_out("R2 short top", 6'h00, 4'h0, 3'd3, 1'b0);
    endtask

    task automatic t_procs;
        for (int id = 1; id <= 6; id++) begin
            logic [31:0] a;
            a = (32'(id) << 19) | 32'h0000_0123;
            apply(1'b1, id[0], a, 4'd2);
            check_out($sformatf("R3 proc id %0d", id), 6'(1 << (id - 1)), 4'h0, 3'd4, 1'b0);
        end
        apply(1'b1, 1'b1, 32'h0037_FFFF, 4'd0);
        check_out("R3 proc 6 top", 6'h20, 4'h0, 3'd4, 1'b0);
    endtask

    task automatic t_bcast;
        apply(1'b1, 1'b1, 32'h0038_0004, 4'd0);
        check_out("R4 bcast write", 6'h3F, 4'h0, 3'd5, 1'b0);
        apply(1'b1, 1'b0, 32'h0038_0004, 4'd0);
        check_out("R5 bcast read", 6'h00, 4'h0, 3'd5, 1'b1);
        apply(1'b1, 1'b1, 32'h003F_FFFF, 4'd0);
        check_out("R4 bcast top", 6'h3F, 4'h0, 3'd5, 1'b0);
    endtask

    task automatic t_banks_small;
        // size 0: banks of 0x2000 words starting at 0x0040_0000
        apply(1'b1, 1'b0, 32'h0040_0000, 4'd0);
        check_out("R6 bank0 base", 6'h00, 4'h1, 3'd6, 1'b0);
        apply(1'b1, 1'b0, 32'h0040_1FFF, 4'd0);
        check_out("R6 bank0 top", 6'h00, 4'h1, 3'd6, 1'b0);
        apply(1'b1, 1'b1, 32'h0040_2000, 4'd0);
        check_out("R6 bank1 base", 6'h00, 4'h2, 3'd6, 1'b0);
        apply(1'b1, 1'b1, 32'h0040_5000, 4'd0);
        check_out("R6 bank2", 6'h00, 4'h4, 3'd6, 1'b0);
        apply(1'b1, 1'b0, 32'h0040_7FFF, 4'd0);
        check_out("R6 bank3 top", 6'h00, 4'h8, 3'd6, 1'b0);
        apply(1'b1, 1'b0, 32'h0040_8000, 4'd0);
        check_out("R7 nonbank base", 6'h00, 4'h0, 3'd7, 1'b0);
        apply(1'b1, 1'b1, 32'hFFFF_FFFF, 4'd0);
        check_out("R7 nonbank top", 6'h00, 4'h0, 3'd7, 1'b0);
    endtask

    task automatic t_banks_sized;
        // size 3: banks of 0x1_0000 words
        apply(1'b1, 1'b0, 32'h0043_FFFF, 4'd3);
        check_out("R8 size3 bank3 top", 6'h00, 4'h8, 3'd6, 1'b0);
        apply(1'b1, 1'b0, 32'h0044_0000, 4'd3);
        check_out("R8 size3 nonbank", 6'h00, 4'h0, 3'd7, 1'b0);
        // size 15: banks of 0x1000_0000 words
        apply(1'b1, 1'b0, 32'h1040_0000, 4'd15);
        check_out("R8 size15 bank1", 6'h00, 4'h2, 3'd6, 1'b0);
        apply(1'b1, 1'b0, 32'h403F_FFFF, 4'd15);
        check_out("R8 size15 bank3 top", 6'h00, 4'h8, 3'd6, 1'b0);
        apply(1'b1, 1'b0, 32'h4040_0000, 4'd15);
        check_out("R8 size15 nonbank", 6'h00, 4'h0, 3'd7, 1'b0);
        // same address, only the size field changes
        apply(1'b1, 1'b0, 32'h0040_8000, 4'd1);
        check_out("R8 move to bank2", 6'h00, 4'h4, 3'd6, 1'b0);
        apply(1'b1, 1'b0, 32'h0040_8000, 4'd2);
        check_out("R8 move to bank1", 6'h00, 4'h2, 3'd6, 1'b0);
    endtask

    task automatic t_latency;
        apply(1'b1, 1'b1, 32'h0008_0000, 4'd0);
        check_out("R9 first", 6'h01, 4'h0, 3'd4, 1'b0);
        req_addr_i = 32'h0040_2000;
        #1;
        check_out("R9 held before edge", 6'h01, 4'h0, 3'd4, 1'b0);
        @(negedge clk);
        check_out("R9 after edge", 6'h00, 4'h2, 3'd6, 1'b0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_idle();
        t_local();
        t_procs();
        t_bcast();
        t_banks_small();
        t_banks_sized();
        t_latency();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

endmodule